// File: doc/BRIEF.md
# Pneumatic Cylinder Cycle Sequencer

This block runs one single-acting pneumatic cylinder through a fixed number of work cycles from a single press of a start button. The solenoid valve is energized, so the cylinder extends. Once the cylinder reaches the end of its stroke, the block waits for a first dwell. It then releases the valve so the cylinder returns, and waits for a second dwell. If the programmed number of cycles has not yet been reached, the valve is energized again.

Both dwells are timed in coarse 100 ms ticks. Each dwell has its own preset, given in ticks. A cycle counter advances at the end of every first dwell. At the end of a second dwell, the block compares the counter with the cycle preset and stops when the two are equal. The start button and the end-of-stroke switch come from the field, so each passes through a register synchronizer before the block uses it. The tick is a one-clock pulse that already belongs to the clock domain.

When the block rests, a done flag shows that the batch is complete. A new press of the start button begins another batch.

Top module: `cyl_cycle_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `valve_on`, `busy` and `done` are all low. Reset also clears the cycle counter, so a batch started after a reset performs exactly `cycle_preset` extensions.
- R2: A low-to-high change of `start_btn` is accepted only while the block is resting (idle, or done). If `cycle_preset` is nonzero, `valve_on` and `busy` go high and `done` goes low. If `cycle_preset` is zero, the block goes straight to done and the valve never opens.
- R3: A change of `start_btn` that rises while `busy` is high has no effect on the batch. The same holds for a button that is held high from the middle of a batch until after the batch ends. The number of extensions stays equal to `cycle_preset`, and `done` stays high once reached.
- R4: After the valve opens, the block keeps it open and waits for a low-to-high change of the synchronized `end_switch`. It does not act on a switch level that is still high from the previous stroke.
- R5: The end-of-stroke dwell lasts exactly `dwell_end_preset` ticks, counting the ticks sampled while in that dwell. A preset of 0 ends the dwell in the cycle after it is entered. The valve stays open throughout the dwell and closes when it ends.
- R6: The cycle counter advances by one exactly when the end-of-stroke dwell ends, and at no other time.
- R7: The return dwell lasts exactly `dwell_home_preset` ticks with `valve_on` low and `busy` high. A preset of 0 makes the dwell one cycle long.
- R8: When the return dwell ends and the counter equals `cycle_preset`, the block goes to done. It then shows `done` high, `busy` low and `valve_on` low. Otherwise the valve opens again. The number of extensions in a batch equals `cycle_preset` for any value from 1 to 255.
- R9: `done` stays high until reset or until a start is accepted.
- R10: `busy` and `done` are never high together, and `valve_on` is high only while `busy` is high.
- R11: Each of `start_btn` and `end_switch` is synchronized through `SYNC_STAGES` registers (default 2), and a change is detected one register later. With the default setting, a start press driven before clock edge k shows `valve_on` high after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Start pushbutton, asynchronous level |
| end_switch | input | 1 | End-of-stroke limit switch, asynchronous level |
| tick_100ms | input | 1 | One-clock pulse every 100 ms |
| dwell_end_preset | input | TIME_W (8) | End-of-stroke dwell length in ticks |
| dwell_home_preset | input | TIME_W (8) | Return dwell length in ticks |
| cycle_preset | input | CYC_W (8) | Number of extend/return cycles per batch |
| valve_on | output | 1 | Solenoid valve drive |
| busy | output | 1 | A batch is running |
| done | output | 1 | The last batch completed |

## Verification
Two functions of the block can fall in the same cycle. A start press can be level-high while the batch reaches its final count and settles into done. A rising edge of the button can also arrive in the middle of a batch. The bench provokes both cases: it pulses the button during a run, and it raises the button mid-batch and holds it past the end of the batch. In both cases it judges the result by the number of valve openings, which must equal the cycle preset, and by `done` staying high after the button is released. A sweep over small dwell and cycle presets counts the ticks seen in each dwell against its preset and the extensions against the cycle count. The sweep includes the zero presets, where a dwell coincides with the entry into its own state.

// File: rtl/cylseq_pkg.sv
package cylseq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_EXTEND   = 3'd1,
        SEQ_DWELL    = 3'd2,
        SEQ_RETRACT  = 3'd3,
        SEQ_FINISHED = 3'd4
    } seq_state_e;

    localparam int TIMER_COUNT = 2;
    localparam int TMR_END     = 0;
    localparam int TMR_HOME    = 1;

    typedef struct packed {
        logic valve;
        logic busy;
        logic done;
    } seq_out_t;

    function automatic seq_out_t decode_out(seq_state_e s);
        seq_out_t o;
        o.valve = (s == SEQ_EXTEND) || (s == SEQ_DWELL);
        o.busy  = (s == SEQ_EXTEND) || (s == SEQ_DWELL) || (s == SEQ_RETRACT);
        o.done  = (s == SEQ_FINISHED);
        return o;
    endfunction

    function automatic logic accepts_start(seq_state_e s);
        return (s == SEQ_IDLE) || (s == SEQ_FINISHED);
    endfunction

endpackage

// File: rtl/cylseq_sync_edge.sv
module cylseq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              prev;
    logic              level;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            prev <= 1'b0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
            prev <= level;
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = level & ~prev;

    // R11: a detected edge is a single-cycle event
    p_single_rise_r11: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/cylseq_dwell_timer.sv
module cylseq_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] preset,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick && (cnt < preset)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = en && (cnt >= preset);

    // R5: leaving the dwell state clears the elapsed count
    p_clear_off_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));
    // R5: without a tick the elapsed count holds
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/cylseq_cycle_counter.sv
module cylseq_cycle_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] preset,
    output logic         reached
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt == preset);

    // R6: one step per completed end-of-stroke dwell
    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));
    // R6: no drift while idle
    p_still_r6: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> (cnt == $past(cnt)));
    // R1: a new batch starts from zero
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/cyl_cycle_sequencer.sv
module cyl_cycle_sequencer
    import cylseq_pkg::*;
#(
    parameter int TIME_W      = 8,
    parameter int CYC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_btn,
    input  logic              end_switch,
    input  logic              tick_100ms,
    input  logic [TIME_W-1:0] dwell_end_preset,
    input  logic [TIME_W-1:0] dwell_home_preset,
    input  logic [CYC_W-1:0]  cycle_preset,
    output logic              valve_on,
    output logic              busy,
    output logic              done
);
    seq_state_e state, state_n;
    seq_out_t   outs;
    logic       start_rise, end_rise;
    logic       cnt_clr, cnt_inc, cnt_reached;
    logic [TIMER_COUNT-1:0] tmr_en, tmr_exp;
    logic [TIME_W-1:0]      tmr_preset [TIMER_COUNT];

    cylseq_sync_edge #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(clk), .rst(rst), .din(start_btn), .rise(start_rise)
    );
    cylseq_sync_edge #(.STAGES(SYNC_STAGES)) u_end_sync (
        .clk(clk), .rst(rst), .din(end_switch), .rise(end_rise)
    );

    assign tmr_preset[TMR_END]  = dwell_end_preset;
    assign tmr_preset[TMR_HOME] = dwell_home_preset;
    assign tmr_en[TMR_END]      = (state == SEQ_DWELL);
    assign tmr_en[TMR_HOME]     = (state == SEQ_RETRACT);

    for (genvar g = 0; g < TIMER_COUNT; g++) begin : g_tmr
        cylseq_dwell_timer #(.W(TIME_W)) u_tmr (
            .clk(clk), .rst(rst), .en(tmr_en[g]), .tick(tick_100ms),
            .preset(tmr_preset[g]), .expired(tmr_exp[g])
        );
    end

    cylseq_cycle_counter #(.W(CYC_W)) u_cycles (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .preset(cycle_preset), .reached(cnt_reached)
    );

    always_comb begin
        state_n = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state)
            SEQ_IDLE, SEQ_FINISHED: begin
                if (start_rise) begin
                    cnt_clr = 1'b1;
                    state_n = (cycle_preset == '0) ? SEQ_FINISHED : SEQ_EXTEND;
                end
            end
            SEQ_EXTEND: begin
                if (end_rise) state_n = SEQ_DWELL;
            end
            SEQ_DWELL: begin
                if (tmr_exp[TMR_END]) begin
                    cnt_inc = 1'b1;
                    state_n = SEQ_RETRACT;
                end
            end
            SEQ_RETRACT: begin
                if (tmr_exp[TMR_HOME]) begin
                    state_n = cnt_reached ? SEQ_FINISHED : SEQ_EXTEND;
                end
            end
            default: state_n = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_n;
    end

    assign outs     = decode_out(state);
    assign valve_on = outs.valve;
    assign busy     = outs.busy;
    assign done     = outs.done;

    // R10: flags exclusive, valve only during a batch
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    p_valve_in_batch_r10: assert property (@(posedge clk) disable iff (rst)
        valve_on |-> busy);
    // R2: accepted start opens the valve when cycles are requested
    p_start_open_r2: assert property (@(posedge clk) disable iff (rst)
        (accepts_start(state) && start_rise && (cycle_preset != '0))
        |=> (valve_on && !done));
    p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (accepts_start(state) && start_rise && (cycle_preset == '0))
        |=> (done && !valve_on));
    // R3: a start edge during extension does not disturb it
    p_start_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        ((state == SEQ_EXTEND) && start_rise && !end_rise) |=> (state == SEQ_EXTEND));
    // R4: valve kept open until the stroke end is detected
    p_wait_stroke_r4: assert property (@(posedge clk) disable iff (rst)
        ((state == SEQ_EXTEND) && !end_rise) |=> valve_on);
    // R8: final count at return dwell end stops the batch
    p_stop_r8: assert property (@(posedge clk) disable iff (rst)
        ((state == SEQ_RETRACT) && tmr_exp[TMR_HOME] && cnt_reached) |=> (done && !valve_on));
    // R9: done persists without a start edge
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start_rise) |=> done);
endmodule

// File: tb/cyl_cycle_sequencer_test.sv
module cyl_cycle_sequencer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_btn = 1'b0;
    logic       end_switch = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] p_end = 8'd0;
    logic [7:0] p_home = 8'd0;
    logic [7:0] p_cyc = 8'd0;
    logic       valve_on, busy, done;

    always #2 clk = ~clk;

    cyl_cycle_sequencer uut (
        .clk(clk), .rst(rst), .start_btn(start_btn), .end_switch(end_switch),
        .tick_100ms(tick), .dwell_end_preset(p_end), .dwell_home_preset(p_home),
        .cycle_preset(p_cyc), .valve_on(valve_on), .busy(busy), .done(done)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    bit mon_en = 1;
    int ph = 0, on_cnt = 0, rises = 0, t1_seen = 0, t2_seen = 0;
    int exp_t1 = 0, exp_t2 = 0;
    bit t2_armed = 0, saw_stroke = 0;
    logic prev_valve = 1'b0, prev_done = 1'b0;

    task automatic check(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // one clock: observe after the edge, then drive for the next edge
    task automatic cyc();
        bit tk;
        @(negedge clk);
        tk = (ph == 0);
        if (mon_en) begin
            if (!valve_on && prev_valve) begin
                check("R5", "end dwell ticks", t1_seen, exp_t1);
                check("R4", "stroke end reached before release", int'(saw_stroke), 1);
                t1_seen = 0; t2_seen = 0; t2_armed = 1; saw_stroke = 0;
            end
            if (valve_on && !prev_valve) begin
                rises++;
                if (t2_armed) check("R7", "home dwell ticks", t2_seen, exp_t2);
                t2_armed = 0; t2_seen = 0;
            end
            if (done && !prev_done && t2_armed) begin
                check("R7", "final home dwell ticks", t2_seen, exp_t2);
                t2_armed = 0;
            end
            if (valve_on && end_switch && tk) t1_seen++;
            if (!valve_on && busy && tk) t2_seen++;
            if (valve_on && end_switch) saw_stroke = 1;
        end
        prev_valve = valve_on;
        prev_done  = done;
        tick = tk;
        if (!valve_on) end_switch = 1'b0;
        else if (on_cnt >= 3 && ph == 1) end_switch = 1'b1;
        on_cnt = valve_on ? on_cnt + 1 : 0;
        ph = (ph + 1) % 10;
    endtask

    // mode 0: plain, 1: start held from mid-batch past the end, 2: short press mid-batch
    task automatic run_case(int t1, int t2, int n, int mode);
        int k;
        p_end = 8'(t1); p_home = 8'(t2); p_cyc = 8'(n);
        exp_t1 = t1; exp_t2 = t2;
        rises = 0; t1_seen = 0; t2_seen = 0; t2_armed = 0; saw_stroke = 0;
        cyc();
        start_btn = 1'b1;
        cyc();
        check("R11", "valve after one edge", int'(valve_on), 0);
        cyc();
        check("R11", "valve after two edges", int'(valve_on), 0);
        cyc();
        if (n > 0) begin
            check("R2", "valve after accepted start", int'(valve_on), 1);
            check("R2", "done cleared by start", int'(done), 0);
            check("R10", "busy during batch", int'(busy), 1);
        end else begin
            check("R2", "zero preset goes to done", int'(done), 1);
            check("R2", "zero preset keeps valve closed", int'(valve_on), 0);
        end
        if (mode != 1) start_btn = 1'b0;
        k = 0;
        while (!done && k < 20000) begin
            cyc();
            k++;
            if (mode != 0 && k == 15) start_btn = 1'b1;
            if (mode == 2 && k == 18) start_btn = 1'b0;
        end
        check("R8", "done at batch end", int'(done), 1);
        check((mode != 0) ? "R3" : "R6 R8", "extensions in batch", rises, n);
        check("R10", "busy low when done", int'(busy), 0);
        check("R8", "valve closed when done", int'(valve_on), 0);
        repeat (6) cyc();
        check("R9", "done holds", int'(done), 1);
        if (mode == 1) begin
            start_btn = 1'b0;
            repeat (6) cyc();
            check("R3", "held start gives no new batch", int'(done), 1);
            check("R3", "no extension after held start", rises, n);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        check("R1", "valve in reset", int'(valve_on), 0);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        rst = 1'b0;
        cyc();
        check("R1", "done after reset", int'(done), 0);

        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 4; b += (b == 1) ? 2 : 1)
                for (int c = 1; c <= 3; c++)
                    run_case(a, b, c, 0);

        run_case(2, 1, 0, 0);
        run_case(1, 2, 3, 2);
        run_case(0, 1, 3, 1);
        run_case(0, 0, 255, 0);

        mon_en = 0;
        p_end = 8'd3; p_home = 8'd2; p_cyc = 8'd5;
        start_btn = 1'b1;
        repeat (3) cyc();
        start_btn = 1'b0;
        repeat (60) cyc();
        check("R1", "batch running before reset", int'(busy), 1);
        rst = 1'b1;
        repeat (2) cyc();
        check("R1", "valve cleared by reset", int'(valve_on), 0);
        check("R1", "busy cleared by reset", int'(busy), 0);
        check("R1", "done cleared by reset", int'(done), 0);
        rst = 1'b0;
        repeat (4) cyc();
        mon_en = 1;
        run_case(1, 0, 2, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule